// File: doc/BRIEF.md
# Call-Gate Privilege Transition Sequencer

This block performs the privileged part of a far call through a call gate. It is handed an already fetched 64-bit gate descriptor, the caller's code segment, instruction pointer, stack segment and stack pointer, and the base address of the task state area. It first checks the gate. If the gate is accepted, it runs a fixed series of single memory accesses through one request port. It reads the target ring's stack pointer and stack segment from the task state area. It then builds the return frame on the new stack and produces the register values that the core loads next.

The target ring is taken from the two low bits of the gate's code selector. A narrow gate (type 4) uses 2-byte stack slots, 16-bit pointer arithmetic and a 16-bit entry offset. A wide gate (type 0xC) uses 4-byte slots and 32-bit values throughout. Stacks grow downward, and each push decrements the pointer before writing. Parameters are copied so that they keep their order: the parameter nearest the caller's stack top ends up nearest the callee's saved frame.

When the gate is rejected, the block gives a one-cycle fault pulse with a reason code. It makes no memory access and does not change its register outputs. When the call is accepted, a one-cycle done pulse marks the cycle in which the new register outputs first hold their values.

Top module: `rg_call_gate_seq`

## Requirements
- R1: After reset, out_cs, out_ip, out_ss and out_sp are zero, and busy, done, fault and mem_req are low.
- R2: A descriptor whose present flag (bit 47) is 0 gives a fault pulse with fault_code 1, with no memory access and no change on the register outputs. This check wins over R3 and R4.
- R3: A present descriptor gives fault_code 2 when bit 44 is 1 or when the type field (bits 43:40) is neither 0x4 nor 0xC. This check wins over R4.
- R4: The call is refused with fault_code 3 when cur_cs[1:0] is numerically greater than the gate privilege field (bits 46:45). Equal values are accepted.
- R5: With target ring r = selector bits 1:0 (selector in descriptor bits 31:16), the stack pointer is read from base+2+4r and the stack segment from base+4+4r for a narrow gate. For a wide gate the addresses are base+4+8r and base+8+8r. The segment read is always a 2-byte access.
- R6: The accesses occur in this order: the pointer read, the segment read, a push of the old SS, a push of the old SP, a read followed by a push for each parameter, a push of the old CS, and a push of the old IP. For n parameters this makes 6+2n accesses.
- R7: Each push writes at pointer minus slot size, where the slot is 2 bytes (narrow) or 4 bytes (wide). Narrow pointers wrap modulo 2^16, and pushed narrow values are cut to 16 bits. mem_wide is 1 for a 4-byte access.
- R8: The parameter count is taken from bits 39:32. Old-stack parameter k (at old SP + k·slot) lands at final SP + (2+k)·slot.
- R9: On done, out_cs is the gate selector and out_ip is the entry offset: {bits 63:48, bits 15:0} for a wide gate, or bits 15:0 zero-extended for a narrow gate. out_ss is the segment read from the task state area, and out_sp is the task-state pointer minus (4+n)·slot.
- R10: done and fault are single-cycle pulses, never high together. The register outputs change only in a cycle where done is high.
- R11: A memory request keeps its address, write flag and data steady until mem_ready is seen, and there is no request while the block is idle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a gate call using the inputs sampled this cycle |
| gate_desc | input | 64 | Call-gate descriptor |
| cur_cs | input | 16 | Caller code segment; bits 1:0 give the current privilege |
| cur_ip | input | 32 | Caller return offset |
| cur_ss | input | 16 | Caller stack segment |
| cur_sp | input | 32 | Caller stack pointer |
| tsr_base | input | 32 | Byte address of the task state area |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 4-byte access, 0 = 2-byte access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: new registers valid |
| fault | output | 1 | One-cycle pulse: gate rejected |
| fault_code | output | 2 | Reason for the last fault (1 absent, 2 bad type, 3 privilege) |
| out_cs | output | 16 | New code segment |
| out_ip | output | 32 | New instruction pointer |
| out_ss | output | 16 | New stack segment |
| out_sp | output | 32 | New stack pointer |

## Verification
Some properties are checked by assertions on every cycle:
- the request-hold rule of the memory handshake;
- the absence of requests while idle;
- that done and fault are one-cycle pulses that exclude each other;
- that the register outputs move only together with done;
- that the parameter counter never steps below zero.

Other behaviour can only be shown by the bench scenarios, because it depends on the contents of memory after the sequence:
- the task-state addresses chosen for each ring and gate width;
- the order of the accesses;
- the parameter layout on the new stack;
- the final stack pointer, including the 16-bit wrap;
- the fault priority.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int WORD_W = 32;
  localparam int SEG_W  = 16;
  localparam int CNT_W  = 8;
  localparam int DESC_W = 64;
  localparam int RING_W = 2;
  localparam logic [3:0] TYPE_NARROW = 4'h4;
  localparam logic [3:0] TYPE_WIDE   = 4'hC;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_TYPE   = 2'd2,
    FLT_PRIV   = 2'd3
  } fault_e;

  typedef struct packed {
    logic [SEG_W-1:0]  off_hi;
    logic              present;
    logic [RING_W-1:0] dpl;
    logic              sys_bit;
    logic [3:0]        gtype;
    logic [CNT_W-1:0]  pcount;
    logic [SEG_W-1:0]  sel;
    logic [SEG_W-1:0]  off_lo;
  } gate_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_RD_SP, ST_RD_SS, ST_PU_SS, ST_PU_SP,
    ST_RD_PRM, ST_PU_PRM, ST_PU_CS, ST_PU_IP
  } step_e;

  function automatic logic [WORD_W-1:0] slot_bytes(input logic wide);
    return wide ? WORD_W'(4) : WORD_W'(2);
  endfunction

  function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v : {{(WORD_W-SEG_W){1'b0}}, v[SEG_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] sp_sub(input logic [WORD_W-1:0] sp,
                                               input logic [WORD_W-1:0] n,
                                               input logic wide);
    return fit(sp - n, wide);
  endfunction

  function automatic logic [WORD_W-1:0] sp_add(input logic [WORD_W-1:0] sp,
                                               input logic [WORD_W-1:0] n,
                                               input logic wide);
    return fit(sp + n, wide);
  endfunction

  function automatic logic [WORD_W-1:0] tss_sp_off(input logic wide, input logic [RING_W-1:0] r);
    logic [WORD_W-1:0] rr;
    rr = {{(WORD_W-RING_W){1'b0}}, r};
    return wide ? (WORD_W'(4) + (rr << 3)) : (WORD_W'(2) + (rr << 2));
  endfunction

  function automatic logic [WORD_W-1:0] tss_ss_off(input logic wide, input logic [RING_W-1:0] r);
    logic [WORD_W-1:0] rr;
    rr = {{(WORD_W-RING_W){1'b0}}, r};
    return wide ? (WORD_W'(8) + (rr << 3)) : (WORD_W'(4) + (rr << 2));
  endfunction

  // offset of the highest not-yet-copied parameter above the old stack top
  function automatic logic [WORD_W-1:0] prm_off(input logic [CNT_W-1:0] left, input logic wide);
    logic [CNT_W-1:0]  idx;
    logic [WORD_W-1:0] k;
    idx = left - 1'b1;
    k   = {{(WORD_W-CNT_W){1'b0}}, idx};
    return wide ? (k << 2) : (k << 1);
  endfunction

  function automatic logic [WORD_W-1:0] entry_ip(input gate_t g, input logic wide);
    return wide ? {g.off_hi, g.off_lo} : {{(WORD_W-SEG_W){1'b0}}, g.off_lo};
  endfunction

  function automatic fault_e classify(input gate_t g, input logic [RING_W-1:0] cpl);
    if (!g.present) return FLT_ABSENT;
    if (g.sys_bit || (g.gtype != TYPE_NARROW && g.gtype != TYPE_WIDE)) return FLT_TYPE;
    if (cpl > g.dpl) return FLT_PRIV;
    return FLT_NONE;
  endfunction
endpackage

// File: rtl/rg_gate_decode.sv
module rg_gate_decode
  import rg_pkg::*;
(
  input  gate_t               gate,
  input  logic [RING_W-1:0]   cpl,
  output fault_e              verdict,
  output logic                wide,
  output logic [RING_W-1:0]   tgt_ring,
  output logic [WORD_W-1:0]   entry,
  output logic [SEG_W-1:0]    sel,
  output logic [CNT_W-1:0]    pcount,
  output logic                has_params
);
  always_comb begin
    verdict    = classify(gate, cpl);
    wide       = (gate.gtype == TYPE_WIDE);
    tgt_ring   = gate.sel[RING_W-1:0];
    entry      = entry_ip(gate, wide);
    sel        = gate.sel;
    pcount     = gate.pcount;
    has_params = (gate.pcount != '0);
  end
endmodule

// File: rtl/rg_stack_unit.sv
module rg_stack_unit
  import rg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              load_sp,
  input  logic [WORD_W-1:0] sp_in,
  input  logic              push_ack,
  input  logic              load_cnt,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              cnt_dec,
  output logic [WORD_W-1:0] nsp,
  output logic [WORD_W-1:0] push_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_last
);
  assign push_addr = sp_sub(nsp, slot_bytes(wide), wide);
  assign cnt_last  = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsp <= '0;
      cnt <= '0;
    end else begin
      if (load_sp)       nsp <= sp_in;
      else if (push_ack) nsp <= push_addr;
      if (load_cnt)      cnt <= cnt_in;
      else if (cnt_dec)  cnt <= cnt - 1'b1;
    end
  end

  // R8
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> (cnt != '0));
endmodule

// File: rtl/rg_call_gate_seq.sv
module rg_call_gate_seq
  import rg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DESC_W-1:0] gate_desc,
  input  logic [SEG_W-1:0]  cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [SEG_W-1:0]  cur_ss,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] tsr_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [SEG_W-1:0]  out_cs,
  output logic [WORD_W-1:0] out_ip,
  output logic [SEG_W-1:0]  out_ss,
  output logic [WORD_W-1:0] out_sp
);
  step_e             st;
  gate_t             gate_q;
  logic [SEG_W-1:0]  cs_q, ss_q, new_ss_q;
  logic [WORD_W-1:0] ip_q, sp_q, base_q, prm_q;

  fault_e            verdict;
  logic              wide, has_params;
  logic [RING_W-1:0] tgt_ring;
  logic [WORD_W-1:0] entry;
  logic [SEG_W-1:0]  sel;
  logic [CNT_W-1:0]  pcount;

  logic [WORD_W-1:0] nsp, push_addr;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_last;

  // named internal events
  logic              acc_ok, push_ack, sp_load, cnt_load, cnt_step;
  logic [WORD_W-1:0] tss_sp_addr, tss_ss_addr, prm_addr;

  rg_gate_decode u_dec (
    .gate(gate_q), .cpl(cs_q[RING_W-1:0]), .verdict(verdict), .wide(wide),
    .tgt_ring(tgt_ring), .entry(entry), .sel(sel), .pcount(pcount),
    .has_params(has_params)
  );

  assign acc_ok      = mem_req && mem_ready;
  assign push_ack    = acc_ok && mem_we;
  assign sp_load     = acc_ok && (st == ST_RD_SP);
  assign cnt_load    = (st == ST_CHECK);
  assign cnt_step    = acc_ok && (st == ST_PU_PRM);
  assign tss_sp_addr = base_q + tss_sp_off(wide, tgt_ring);
  assign tss_ss_addr = base_q + tss_ss_off(wide, tgt_ring);
  assign prm_addr    = sp_add(sp_q, prm_off(cnt, wide), wide);
  assign busy        = (st != ST_IDLE);

  rg_stack_unit u_stk (
    .clk(clk), .rst_n(rst_n), .wide(wide),
    .load_sp(sp_load), .sp_in(fit(mem_rdata, wide)),
    .push_ack(push_ack), .load_cnt(cnt_load), .cnt_in(pcount), .cnt_dec(cnt_step),
    .nsp(nsp), .push_addr(push_addr), .cnt(cnt), .cnt_last(cnt_last)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wide  = wide;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_RD_SP:  begin mem_req = 1'b1; mem_addr = tss_sp_addr; end
      ST_RD_SS:  begin mem_req = 1'b1; mem_wide = 1'b0; mem_addr = tss_ss_addr; end
      ST_RD_PRM: begin mem_req = 1'b1; mem_addr = prm_addr; end
      ST_PU_SS:  begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
        mem_wdata = {{(WORD_W-SEG_W){1'b0}}, ss_q};
      end
      ST_PU_SP:  begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
        mem_wdata = fit(sp_q, wide);
      end
      ST_PU_PRM: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
        mem_wdata = prm_q;
      end
      ST_PU_CS:  begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
        mem_wdata = {{(WORD_W-SEG_W){1'b0}}, cs_q};
      end
      ST_PU_IP:  begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
        mem_wdata = fit(ip_q, wide);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      gate_q     <= '0;
      cs_q       <= '0;
      ip_q       <= '0;
      ss_q       <= '0;
      sp_q       <= '0;
      base_q     <= '0;
      new_ss_q   <= '0;
      prm_q      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      out_cs     <= '0;
      out_ip     <= '0;
      out_ss     <= '0;
      out_sp     <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          gate_q <= gate_t'(gate_desc);
          cs_q   <= cur_cs;
          ip_q   <= cur_ip;
          ss_q   <= cur_ss;
          sp_q   <= cur_sp;
          base_q <= tsr_base;
          st     <= ST_CHECK;
        end
        ST_CHECK: if (verdict != FLT_NONE) begin
          fault      <= 1'b1;
          fault_code <= verdict;
          st         <= ST_IDLE;
        end else begin
          st <= ST_RD_SP;
        end
        ST_RD_SP: if (acc_ok) st <= ST_RD_SS;
        ST_RD_SS: if (acc_ok) begin
          new_ss_q <= mem_rdata[SEG_W-1:0];
          st       <= ST_PU_SS;
        end
        ST_PU_SS: if (acc_ok) st <= ST_PU_SP;
        ST_PU_SP: if (acc_ok) st <= has_params ? ST_RD_PRM : ST_PU_CS;
        ST_RD_PRM: if (acc_ok) begin
          prm_q <= fit(mem_rdata, wide);
          st    <= ST_PU_PRM;
        end
        ST_PU_PRM: if (acc_ok) st <= cnt_last ? ST_PU_CS : ST_RD_PRM;
        ST_PU_CS: if (acc_ok) st <= ST_PU_IP;
        ST_PU_IP: if (acc_ok) begin
          out_cs <= sel;
          out_ip <= entry;
          out_ss <= new_ss_q;
          out_sp <= push_addr;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_wide)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  fault_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_cs) && $stable(out_ip) && $stable(out_ss) && $stable(out_sp)));
  // R2
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code != 2'd0));
endmodule

// File: tb/tb_rg_call_gate_seq.sv
module tb_rg_call_gate_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] gate_desc = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic [31:0] cur_ip = '0, cur_sp = '0, tsr_base = '0;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, fault;
  logic [1:0]  fault_code;
  logic [15:0] out_cs, out_ss;
  logic [31:0] out_ip, out_sp;

  always #5 clk = ~clk;

  rg_call_gate_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_desc(gate_desc),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .tsr_base(tsr_base), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
    .fault_code(fault_code), .out_cs(out_cs), .out_ip(out_ip), .out_ss(out_ss),
    .out_sp(out_sp)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int stall_mode = 0;
  int stall_ctr = 0;

  logic [7:0]  mem [0:4095];
  logic        log_we   [0:63];
  logic [31:0] log_addr [0:63];
  int          log_n = 0;

  function automatic logic [63:0] mk_gate(input logic [31:0] off, input logic [15:0] sel,
                                          input logic [7:0] n, input logic [3:0] typ,
                                          input logic [1:0] dpl, input logic p);
    return {off[31:16], p, dpl, 1'b0, typ, n, sel, off[15:0]};
  endfunction

  typedef struct packed {
    logic [63:0] desc;
    logic [15:0] cs;
    logic [31:0] ip;
    logic [15:0] ss;
    logic [31:0] sp;
    logic [31:0] tbase;
    logic [31:0] tsp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{mk_gate(32'hABCD_1234, 16'h0028, 8'd2, 4'h4, 2'd3, 1'b1), 16'h001B, 32'h0000_5678, 16'h0023, 32'h0000_0400, 32'h0000_0100, 32'h0000_0800},
    '{mk_gate(32'h0012_3456, 16'h0031, 8'd3, 4'hC, 2'd3, 1'b1), 16'h002A, 32'h1000_2000, 16'h0042, 32'h0000_0480, 32'h0000_0140, 32'h7000_0900},
    '{mk_gate(32'hDEAD_0010, 16'h003A, 8'd0, 4'hC, 2'd2, 1'b1), 16'h0012, 32'h2222_0030, 16'h0017, 32'h0000_0440, 32'h0000_0180, 32'h0000_0700},
    '{mk_gate(32'h0000_1000, 16'h0008, 8'd1, 4'hC, 2'd3, 1'b0), 16'h0003, 32'h0000_0040, 16'h0010, 32'h0000_0300, 32'h0000_0100, 32'h0000_0800},
    '{mk_gate(32'h0000_1000, 16'h0008, 8'd1, 4'h5, 2'd3, 1'b1), 16'h0003, 32'h0000_0040, 16'h0010, 32'h0000_0300, 32'h0000_0100, 32'h0000_0800},
    '{mk_gate(32'h0000_1000, 16'h0008, 8'd1, 4'hC, 2'd1, 1'b1), 16'h0003, 32'h0000_0040, 16'h0010, 32'h0000_0300, 32'h0000_0100, 32'h0000_0800},
    '{mk_gate(32'h0000_1000, 16'h0008, 8'd1, 4'h0, 2'd0, 1'b0), 16'h0003, 32'h0000_0040, 16'h0010, 32'h0000_0300, 32'h0000_0100, 32'h0000_0800},
    '{mk_gate(32'h0000_0100, 16'h0008, 8'd1, 4'h4, 2'd3, 1'b1), 16'h0003, 32'h0000_0777, 16'h0010, 32'h0000_0300, 32'h0000_01C0, 32'h0000_0004}
  };

  task automatic wr(input logic [31:0] a, input logic [31:0] v, input int nb);
    for (int j = 0; j < nb; j++) mem[12'(a[11:0] + 12'(j))] = v[8*j +: 8];
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a, input int nb);
    logic [31:0] r = '0;
    for (int j = 0; j < nb; j++) r[8*j +: 8] = mem[12'(a[11:0] + 12'(j))];
    return r;
  endfunction

  // memory responder: decides acceptance away from the active edge
  always @(negedge clk) begin
    cycles = cycles + 1;
    stall_ctr = stall_ctr + 1;
    if (mem_req && (stall_mode == 0 || (stall_ctr % (stall_mode + 1)) == 0)) begin
      mem_ready = 1'b1;
      if (mem_we) wr(mem_addr, mem_wdata, mem_wide ? 4 : 2);
      else mem_rdata = rd(mem_addr, mem_wide ? 4 : 2);
      if (log_n < 64) begin
        log_we[log_n] = mem_we;
        log_addr[log_n] = mem_addr;
      end
      log_n = log_n + 1;
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [63:0] d, input logic [15:0] cs);
    if (d[47] == 1'b0) return 2'd1;
    if (d[44:40] != 5'h04 && d[44:40] != 5'h0C) return 2'd2;
    if (cs[1:0] > d[46:45]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic apply(input vec_t v);
    gate_desc = v.desc; cur_cs = v.cs; cur_ip = v.ip;
    cur_ss = v.ss; cur_sp = v.sp; tsr_base = v.tbase;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output logic got_done, output logic got_fault);
    int n = 0;
    while (!(done || fault) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    got_done = done;
    got_fault = fault;
    if (!(got_done || got_fault)) check("R10", "completion timeout", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input int i, input bit interfere);
    vec_t v = VT[i];
    logic wide = (v.desc[43:40] == 4'hC);
    int sz = wide ? 4 : 2;
    int n = int'(v.desc[39:32]);
    int r = int'(v.desc[17:16]);
    logic [1:0] ef = exp_fault(v.desc, v.cs);
    logic [31:0] tsp_r, fsp, eip;
    logic [15:0] pcs, pss;
    logic [31:0] pip, psp;
    logic gd, gf;

    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    log_n = 0;
    stall_mode = i % 3;
    for (int q = 0; q < 3; q++) begin
      logic [31:0] s = v.tsp + 32'(q) * 32'h100;
      if (wide) begin
        wr(v.tbase + 32'(4 + 8*q), s, 4);
        wr(v.tbase + 32'(8 + 8*q), 32'h50 + 32'(q), 2);
      end else begin
        wr(v.tbase + 32'(2 + 4*q), s, 2);
        wr(v.tbase + 32'(4 + 4*q), 32'h50 + 32'(q), 2);
      end
    end
    for (int k = 0; k < n; k++)
      wr(v.sp + 32'(k * sz), 32'hC0DE_0000 + 32'(i << 8) + 32'(k), sz);
    pcs = out_cs; pip = out_ip; pss = out_ss; psp = out_sp;

    apply(v);
    if (interfere) begin
      @(negedge clk);
      gate_desc = VT[3].desc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_end(gd, gf);

    if (ef != 2'd0) begin
      check(ef == 2'd1 ? "R2" : (ef == 2'd2 ? "R3" : "R4"), "fault pulse", {31'd0, gf}, 32'd1);
      check(ef == 2'd1 ? "R2" : (ef == 2'd2 ? "R3" : "R4"), "fault_code", {30'd0, fault_code}, {30'd0, ef});
      check("R2", "no access on fault", 32'(log_n), 32'd0);
      check("R10", "regs kept on fault",
            {out_cs ^ pcs, out_ss ^ pss} | (out_ip ^ pip) | (out_sp ^ psp), 32'd0);
      @(negedge clk);
      check("R10", "fault one cycle", {31'd0, fault}, 32'd0);
      return;
    end

    tsp_r = v.tsp + 32'(r) * 32'h100;
    if (!wide) tsp_r = {16'h0, tsp_r[15:0]};
    fsp = tsp_r - 32'((4 + n) * sz);
    if (!wide) fsp = {16'h0, fsp[15:0]};
    eip = wide ? {v.desc[63:48], v.desc[15:0]} : {16'h0, v.desc[15:0]};

    check("R9", "done pulse", {31'd0, gd}, 32'd1);
    check("R9", "out_cs", {16'h0, out_cs}, {16'h0, v.desc[31:16]});
    check("R9", "out_ip", out_ip, eip);
    check("R9", "out_ss", {16'h0, out_ss}, 32'h50 + 32'(r));
    check("R7", "out_sp", out_sp, fsp);
    check("R7", "pushed ip", rd(fsp, sz), wide ? v.ip : {16'h0, v.ip[15:0]});
    check("R7", "pushed cs", rd(fsp + 32'(sz), sz), {16'h0, v.cs});
    for (int k = 0; k < n; k++) begin
      logic [31:0] pv = 32'hC0DE_0000 + 32'(i << 8) + 32'(k);
      check("R8", "param order", rd(fsp + 32'((2 + k) * sz), sz), wide ? pv : {16'h0, pv[15:0]});
    end
    check("R7", "pushed old sp", rd(fsp + 32'((2 + n) * sz), sz), wide ? v.sp : {16'h0, v.sp[15:0]});
    check("R7", "pushed old ss", rd(fsp + 32'((3 + n) * sz), sz), {16'h0, v.ss});
    check("R6", "access count", 32'(log_n), 32'(6 + 2 * n));
    check("R5", "tss sp addr", log_addr[0], v.tbase + 32'(wide ? 4 + 8*r : 2 + 4*r));
    check("R5", "tss ss addr", log_addr[1], v.tbase + 32'(wide ? 8 + 8*r : 4 + 4*r));
    check("R6", "reads first", {30'd0, log_we[0], log_we[1]}, 32'd0);
    check("R6", "first push addr", log_addr[2],
          wide ? tsp_r - 32'(sz) : {16'h0, 16'(tsp_r[15:0] - 16'(sz))});
    check("R6", "last push at final sp", log_addr[5 + 2 * n], fsp);
    @(negedge clk);
    check("R10", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset regs", {out_cs, out_ss} | out_ip | out_sp, 32'd0);
    check("R1", "reset flags", {28'd0, busy, done, fault, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {30'd0, busy, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

    // R11 start during a sequence has no effect
    run_vec(0, 1'b1);
    check("R11", "idle after ignored start", {31'd0, busy}, 32'd0);

    // R4 equal privilege accepted after a fault leaves outputs intact
    run_vec(5, 1'b0);
    run_vec(2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule